// File: doc/BRIEF.md
# Debug Port Reset Mode Sampler

This block decides, once per soft-reset release, how the serial debug port of a processor will operate. Two configuration pins are sampled at separate moments after the active-low soft reset is released. The debug clock pin is read on the release edge itself. Its level sets a sticky debug-enable flag and makes a one-cycle request that the core halt into the debug state as soon as reset ends. A fixed number of system clocks later, the serial data-in pin is read once. Its level fixes the transfer clocking: either the externally supplied debug clock (asynchronous) or the internal system clock (synchronous).

All three pins are asynchronous to the system clock. Each passes through a two-flop synchroniser before any edge detection or sampling. The latched results and a valid flag stay cleared for as long as the synchronised soft reset is low. Every new reset assertion re-arms the sampler, including one that arrives while a sample window is still open. Downstream port logic should treat the clock-mode output as meaningful only while the valid flag is high.

Top module: `dbg_rst_sampler`

## Requirements
- R1: While `rst` is high, all four outputs are 0 (async mode is encoded as `sync_mode` = 0).
- R2: Three clock edges after `srst_n` is first sampled low, all four outputs are 0, and they stay 0 while `srst_n` stays low.
- R3: If `srst_n` is first sampled high at clock edge A1, then `dbg_en` takes the level of `dbg_clk_pin` sampled at that same edge A1, and it is visible after edge A3.
- R4: When that captured level is 1, `halt_req` is high for exactly the one cycle after edge A3. When the captured level is 0, `halt_req` stays low.
- R5: `sync_mode` takes the level of `dbg_din_pin` sampled at edge A9, which is exactly 8 clocks after the edge at which the enable is taken. A 0 means asynchronous mode and a 1 means synchronous mode. The result is visible after edge A11.
- R6: `cfg_valid` rises after the same edge A11 at which `sync_mode` is updated. It is 0 before that edge and stays 1 until the next reset.
- R7: Once captured, `dbg_en` and `sync_mode` ignore any later change on `dbg_clk_pin` and `dbg_din_pin` until the next reset.
- R8: A soft reset asserted before the clock-mode sample is taken aborts the window, so `cfg_valid` stays 0. The next release restarts the full sequence of R3 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| srst_n | input | 1 | Asynchronous active-low soft reset pin |
| dbg_clk_pin | input | 1 | Debug clock pin, read at release as the debug enable strap |
| dbg_din_pin | input | 1 | Serial data-in pin, read later as the clock-mode strap |
| dbg_en | output | 1 | Latched debug-mode enable |
| sync_mode | output | 1 | Latched clock mode: 0 asynchronous, 1 synchronous |
| cfg_valid | output | 1 | Both latched values are valid |
| halt_req | output | 1 | One-cycle request to halt into debug right after reset |

## Verification
Each release is run with the debug clock pin held at a chosen level only at the release edge and randomised on every other cycle. The data-in pin carries its chosen level only at the single edge that R5 names and random values elsewhere. A sample taken one cycle early or late therefore gives a different result on most runs. All four combinations of enable and clock mode are driven directly, then more releases are run with random levels. After each capture, the pins keep toggling to show that the latched values hold. A reset dropped in the middle of the window checks the abort-and-re-arm path against the full sequence that follows it.

// File: rtl/dbgs_pkg.sv
package dbgs_pkg;
  typedef enum logic { CLK_ASYNC = 1'b0, CLK_SYNC = 1'b1 } clk_mode_t;
  typedef enum logic [1:0] { ST_IDLE = 2'd0, ST_COUNT = 2'd1, ST_DONE = 2'd2 } samp_st_t;
endpackage

// File: rtl/dbgs_sync.sv
module dbgs_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgs_edge.sv
module dbgs_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise
);
  logic prev;
  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= lvl;
  end
  assign rise = lvl & ~prev;
endmodule

// File: rtl/dbgs_capture.sv
module dbgs_capture
  import dbgs_pkg::*;
#(
  parameter int SAMPLE_DLY = 8,
  localparam int CNT_W = $clog2(SAMPLE_DLY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic rst_lvl_n,
  input  logic rel_rise,
  input  logic clk_strap,
  input  logic din_strap,
  output logic en_q,
  output logic mode_sync,
  output logic valid_q,
  output logic halt_q
);
  samp_st_t   st;
  logic [CNT_W-1:0] cnt;
  clk_mode_t  mode_q;

  always_ff @(posedge clk) begin
    if (rst || !rst_lvl_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      en_q    <= 1'b0;
      mode_q  <= CLK_ASYNC;
      valid_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      halt_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (rel_rise) begin
          en_q   <= clk_strap;
          halt_q <= clk_strap;
          cnt    <= CNT_W'(1);
          st     <= ST_COUNT;
        end
        ST_COUNT: if (cnt == CNT_W'(SAMPLE_DLY)) begin
          mode_q  <= din_strap ? CLK_SYNC : CLK_ASYNC;
          valid_q <= 1'b1;
          st      <= ST_DONE;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign mode_sync = (mode_q == CLK_SYNC);
endmodule

// File: rtl/dbg_rst_sampler.sv
module dbg_rst_sampler #(
  parameter int SAMPLE_DLY  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic srst_n,
  input  logic dbg_clk_pin,
  input  logic dbg_din_pin,
  output logic dbg_en,
  output logic sync_mode,
  output logic cfg_valid,
  output logic halt_req
);
  localparam int NPIN = 3;
  logic [NPIN-1:0] pins_s;
  logic rel_rise;

  dbgs_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst),
    .d({srst_n, dbg_clk_pin, dbg_din_pin}),
    .q(pins_s)
  );

  dbgs_edge u_edge (
    .clk(clk), .rst(rst), .lvl(pins_s[2]), .rise(rel_rise)
  );

  dbgs_capture #(.SAMPLE_DLY(SAMPLE_DLY)) u_cap (
    .clk(clk), .rst(rst),
    .rst_lvl_n(pins_s[2]), .rel_rise(rel_rise),
    .clk_strap(pins_s[1]), .din_strap(pins_s[0]),
    .en_q(dbg_en), .mode_sync(sync_mode),
    .valid_q(cfg_valid), .halt_q(halt_req)
  );
endmodule

// File: rtl/dbgs_checker.sv
module dbgs_checker (
  input logic clk,
  input logic rst,
  input logic srst_n,
  input logic dbg_en,
  input logic sync_mode,
  input logic cfg_valid,
  input logic halt_req
);
  p_clear_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(srst_n, 2) |=> (!dbg_en && !cfg_valid && !halt_req && !sync_mode));

  p_halt_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    halt_req |=> !halt_req);

  p_halt_en_r4: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> dbg_en);

  p_valid_no_halt_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> !halt_req);

  p_valid_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && srst_n && $past(srst_n)) |=> cfg_valid);

  p_latched_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && srst_n && $past(srst_n)) |=> ($stable(dbg_en) && $stable(sync_mode)));
endmodule

bind dbg_rst_sampler dbgs_checker u_chk (
  .clk(clk), .rst(rst), .srst_n(srst_n),
  .dbg_en(dbg_en), .sync_mode(sync_mode),
  .cfg_valid(cfg_valid), .halt_req(halt_req)
);

// File: tb/dbg_rst_sampler_test.sv
module dbg_rst_sampler_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst, srst_n, dbg_clk_pin, dbg_din_pin;
  logic dbg_en, sync_mode, cfg_valid, halt_req;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_rst_sampler uut (
    .clk(clk), .rst(rst), .srst_n(srst_n),
    .dbg_clk_pin(dbg_clk_pin), .dbg_din_pin(dbg_din_pin),
    .dbg_en(dbg_en), .sync_mode(sync_mode),
    .cfg_valid(cfg_valid), .halt_req(halt_req)
  );

  function automatic logic exp_halt(input logic strap, input int k);
    return (k == 3) ? strap : 1'b0;
  endfunction

  function automatic logic rnd_bit();
    logic [31:0] r;
    r = $urandom();
    return r[0];
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_clear(input string req);
    chk({req, " dbg_en"}, dbg_en, 1'b0);
    chk({req, " sync_mode"}, sync_mode, 1'b0);
    chk({req, " cfg_valid"}, cfg_valid, 1'b0);
    chk({req, " halt_req"}, halt_req, 1'b0);
  endtask

  // negedge k lies after edge A_k; values driven at negedge k reach edge A(k+1)
  task automatic run_release(input logic en_v, input logic mode_v);
    for (int k = 0; k <= 14; k++) begin
      @(negedge clk);
      if (k == 3) begin
        chk("R3 dbg_en", dbg_en, en_v);
        chk("R4 halt_req pulse", halt_req, exp_halt(en_v, k));
        chk("R6 early valid", cfg_valid, 1'b0);
      end
      if (k == 4)  chk("R4 halt_req width", halt_req, exp_halt(en_v, k));
      if (k == 10) chk("R6 valid before sample", cfg_valid, 1'b0);
      if (k == 11) begin
        chk("R5 sync_mode", sync_mode, mode_v);
        chk("R6 valid", cfg_valid, 1'b1);
        chk("R7 dbg_en held", dbg_en, en_v);
      end
      if (k == 0) srst_n = 1'b1;
      dbg_clk_pin = (k == 0) ? en_v : rnd_bit();
      dbg_din_pin = (k == 8) ? mode_v : rnd_bit();
    end
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      dbg_clk_pin = rnd_bit();
      dbg_din_pin = rnd_bit();
    end
    @(negedge clk);
    chk("R7 dbg_en after toggles", dbg_en, en_v);
    chk("R7 sync_mode after toggles", sync_mode, mode_v);
    chk("R6 valid held", cfg_valid, 1'b1);
    srst_n = 1'b0;
    repeat (4) @(negedge clk);
    chk_clear("R2");
  endtask

  initial begin
    void'($urandom(32'd2718));
    rst = 1'b1; srst_n = 1'b0; dbg_clk_pin = 1'b1; dbg_din_pin = 1'b1;
    repeat (4) @(negedge clk);
    chk_clear("R1");
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk_clear("R2 held low");

    run_release(1'b1, 1'b0);
    run_release(1'b1, 1'b1);
    run_release(1'b0, 1'b1);
    run_release(1'b0, 1'b0);

    // R8: abort inside the window, then re-arm
    @(negedge clk);
    srst_n = 1'b1; dbg_clk_pin = 1'b1; dbg_din_pin = 1'b1;
    repeat (6) @(negedge clk);
    srst_n = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 aborted valid", cfg_valid, 1'b0);
    chk("R8 aborted dbg_en", dbg_en, 1'b0);
    run_release(1'b1, 1'b1);

    for (int i = 0; i < 12; i++) run_release(rnd_bit(), rnd_bit());

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule